// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the software-facing front end of one eight-input priority interrupt controller. It sits on a plain synchronous bus with one write strobe, one read strobe, a one-bit address and a byte of data. Writes are sorted into three kinds: the initialization sequence, the operation commands and mask loads. Each write updates a set of registered control fields or raises a one-cycle command to the resolver core that holds the request and in-service state.

On a read it returns the request register, the in-service register or the mask. When a poll has been armed, the read instead returns the winning input, and in the same clock it tells the core to retire that input. The resolver core and any cascading of several controllers are outside this block. The block receives the request and in-service vectors and the current poll winner from the core as inputs.

Top module: `pic_cmd_regif`

## Requirements
- R1: Synchronous active-low reset clears the mask, vector base, nested, auto-EOI, rotate, special-mask and read-select outputs and `rdata`. It puts the sequencer in its normal state.
- R2: An address-0 write with data bit 4 set starts initialization. Data bit 0 records whether a mode word will follow. The write clears the mask, special mask and read select, and drives `core_cmd_o`=1 (init, which clears the core's priority base) in the same cycle.
- R3: An init write with bit 0 clear also clears nested mode and auto-EOI. With bit 0 set, both keep their values.
- R4: The first address-1 write after an init word loads the vector base with the data AND 0xF8.
- R5: The second address-1 write after an init word changes no output. It moves on to the mode-word step only when bit 0 of the init word was set; otherwise the sequencer returns to normal.
- R6: In the mode-word step, data bit 4 sets nested mode and data bit 1 sets auto-EOI, and the sequencer returns to normal.
- R7: In the normal state, an address-1 write loads the mask from the data. An address-1 write during initialization leaves the mask unchanged.
- R8: An address-0 write with bit 4 clear and bit 3 set is a read/mode command. If bit 1 is set, bit 0 sets the read select (1 = in-service, 0 = request). If bit 6 is set, bit 5 sets the special mask. Bit 2 arms a poll.
- R9: Any other address-0 write takes data[7:5] as an operation. In the same cycle it drives `core_cmd_o`/`core_lvl_o` as follows: 1 gives 2/0 (non-specific EOI), 5 gives 3/0 (rotating non-specific EOI), 3 gives 4/data[2:0] (specific EOI), 7 gives 5/data[2:0] (rotating specific EOI) and 6 gives 6/data[2:0] (set priority).
- R10: Operations 0 and 4 clear and set the rotate-on-auto-EOI flag and issue no core command. Operation 2 changes nothing.
- R11: A read loads `rdata` on the clock of `rd_en`, and `rdata` holds that value until the next read. Without a pending poll, address 0 returns the in-service or request vector according to read select, and address 1 returns the mask. `wr_en` and `rd_en` are never high together.
- R12: A read with a poll pending and a winner returns the winning pin in bits 2:0 with the upper bits zero. In the same cycle it drives `core_cmd_o`=7 with the pin on `core_lvl_o`. The poll is consumed, so the following read is an ordinary register read.
- R13: A poll read with no eligible input returns 0x07 and issues no core command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irr_in | input | NUM_PINS | Request vector from the core |
| isr_in | input | NUM_PINS | In-service vector from the core |
| poll_valid | input | 1 | Core has an eligible winner |
| poll_pin | input | LVL_W | Winning input index |
| mask_o | output | NUM_PINS | Mask register |
| vec_base_o | output | DATA_W | Vector base |
| nested_o | output | 1 | Special fully nested mode |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on auto-EOI |
| spec_mask_o | output | 1 | Special mask mode |
| read_isr_o | output | 1 | Read select, 1 = in-service |
| core_cmd_o | output | 3 | Command strobe code to the core, 0 = none |
| core_lvl_o | output | LVL_W | Pin or priority level for the command |

## Verification
The bench aims at the sequencing corners: the ignored third word, the skipped mode word, and an init word that arrives while the mode fields already hold values. A design that miscounts steps would load the mask or vector base from the wrong write. A design that clears mode fields without regard to bit 0 would lose nested mode. The bench also checks that a poll is consumed by exactly one read and that an empty poll returns 0x07 without an acknowledge. A sticky poll flag would turn later register reads into destructive ones. It checks that the no-operation and rotate-flag operations issue no core strobe; a careless decode table would emit spurious EOIs.

// File: rtl/pic_cmd_pkg.sv
// Shared types and bit positions for the command register interface.
// Assumes byte-wide control words; positions are fixed by the command format.
package pic_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_INIT       = 3'd1,
        CMD_EOI_NS     = 3'd2,
        CMD_EOI_NS_ROT = 3'd3,
        CMD_EOI_SP     = 3'd4,
        CMD_EOI_SP_ROT = 3'd5,
        CMD_SET_PRIO   = 3'd6,
        CMD_POLL_ACK   = 3'd7
    } core_cmd_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_SKIP = 2'd2,
        SEQ_MODE = 2'd3
    } seq_e;

    // control-word bit positions
    localparam int B_INIT     = 4;
    localparam int B_OCW3     = 3;
    localparam int B_FOURTH   = 0;
    localparam int B_POLL     = 2;
    localparam int B_RSEL_EN  = 1;
    localparam int B_RSEL_VAL = 0;
    localparam int B_SMM_EN   = 6;
    localparam int B_SMM_VAL  = 5;
    localparam int B_NEST     = 4;
    localparam int B_AEOI     = 1;
    localparam int OP_MSB     = 7;
    localparam int OP_W       = 3;

    // operation codes in data[7:5]
    localparam logic [2:0] OP_ROT_CLR = 3'd0;
    localparam logic [2:0] OP_EOI     = 3'd1;
    localparam logic [2:0] OP_NOP     = 3'd2;
    localparam logic [2:0] OP_SEOI    = 3'd3;
    localparam logic [2:0] OP_ROT_SET = 3'd4;
    localparam logic [2:0] OP_REOI    = 3'd5;
    localparam logic [2:0] OP_PRIO    = 3'd6;
    localparam logic [2:0] OP_RSEOI   = 3'd7;

endpackage

// File: rtl/pic_init_seq.sv
// Initialization sequencer and mask register.
// Owns the mask, vector base, nested and auto-EOI fields. Assumes the caller
// decodes init_hit (address 0, init bit) and data_wr (address 1 write).
module pic_init_seq
    import pic_cmd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_PINS = 8,
    parameter int LVL_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_hit,
    input  logic                data_wr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_PINS-1:0] mask,
    output logic [DATA_W-1:0]   vec_base,
    output logic                nested,
    output logic                aeoi,
    output seq_e                state
);

    localparam logic [DATA_W-1:0] VEC_KEEP = {{(DATA_W-LVL_W){1'b1}}, {LVL_W{1'b0}}};

    logic fourth_due;

    // Step through the init words; in the idle state address-1 data is the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask       <= '0;
            vec_base   <= '0;
            nested     <= 1'b0;
            aeoi       <= 1'b0;
            fourth_due <= 1'b0;
            state      <= SEQ_IDLE;
        end else if (init_hit) begin
            fourth_due <= wdata[B_FOURTH];
            mask       <= '0;
            if (!wdata[B_FOURTH]) begin
                nested <= 1'b0;
                aeoi   <= 1'b0;
            end
            state <= SEQ_BASE;
        end else if (data_wr) begin
            case (state)
                SEQ_IDLE: mask <= wdata[NUM_PINS-1:0];
                SEQ_BASE: begin
                    vec_base <= wdata & VEC_KEEP;
                    state    <= SEQ_SKIP;
                end
                SEQ_SKIP: state <= fourth_due ? SEQ_MODE : SEQ_IDLE;
                SEQ_MODE: begin
                    nested <= wdata[B_NEST];
                    aeoi   <= wdata[B_AEOI];
                    state  <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pic_ocw_dec.sv
// Decoder for address-0 writes that are not init words.
// Sorts them into the read/mode command and the operation command, holds
// the mode flags and the poll request. Assumes init_hit and ctl_wr are
// mutually consistent (init_hit implies ctl_wr).
module pic_ocw_dec
    import pic_cmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              init_hit,
    input  logic              poll_taken,
    input  logic [DATA_W-1:0] wdata,
    output logic              rot_aeoi,
    output logic              spec_mask,
    output logic              read_isr,
    output logic              poll_pend,
    output core_cmd_e         op_cmd,
    output logic [LVL_W-1:0]  op_lvl
);

    logic            ocw3_hit;
    logic            ocw2_hit;
    logic [OP_W-1:0] op;

    // Split control writes by the init and read/mode bits.
    always_comb begin
        ocw3_hit = ctl_wr && !wdata[B_INIT] && wdata[B_OCW3];
        ocw2_hit = ctl_wr && !wdata[B_INIT] && !wdata[B_OCW3];
        op       = wdata[OP_MSB -: OP_W];
    end

    // Map the operation field onto a core command strobe.
    always_comb begin
        op_cmd = CMD_NONE;
        op_lvl = '0;
        if (ocw2_hit) begin
            case (op)
                OP_EOI:  op_cmd = CMD_EOI_NS;
                OP_REOI: op_cmd = CMD_EOI_NS_ROT;
                OP_SEOI: begin
                    op_cmd = CMD_EOI_SP;
                    op_lvl = wdata[LVL_W-1:0];
                end
                OP_RSEOI: begin
                    op_cmd = CMD_EOI_SP_ROT;
                    op_lvl = wdata[LVL_W-1:0];
                end
                OP_PRIO: begin
                    op_cmd = CMD_SET_PRIO;
                    op_lvl = wdata[LVL_W-1:0];
                end
                default: op_cmd = CMD_NONE;
            endcase
        end
    end

    // Hold the mode flags and the one-shot poll request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_aeoi  <= 1'b0;
            spec_mask <= 1'b0;
            read_isr  <= 1'b0;
            poll_pend <= 1'b0;
        end else begin
            if (ocw2_hit && op == OP_ROT_SET)
                rot_aeoi <= 1'b1;
            else if (ocw2_hit && op == OP_ROT_CLR)
                rot_aeoi <= 1'b0;

            if (init_hit) begin
                spec_mask <= 1'b0;
                read_isr  <= 1'b0;
            end else if (ocw3_hit) begin
                if (wdata[B_RSEL_EN])
                    read_isr <= wdata[B_RSEL_VAL];
                if (wdata[B_SMM_EN])
                    spec_mask <= wdata[B_SMM_VAL];
            end

            if (ocw3_hit && wdata[B_POLL])
                poll_pend <= 1'b1;
            else if (poll_taken)
                poll_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/pic_rd_path.sv
// Read data path with the destructive poll read.
// rdata is registered on the read strobe. The poll acknowledge is
// combinational in the same cycle. Assumes NUM_PINS <= DATA_W.
module pic_rd_path #(
    parameter int DATA_W   = 8,
    parameter int NUM_PINS = 8,
    parameter int LVL_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic                addr,
    input  logic                poll_pend,
    input  logic                read_isr,
    input  logic [NUM_PINS-1:0] irr_in,
    input  logic [NUM_PINS-1:0] isr_in,
    input  logic [NUM_PINS-1:0] mask,
    input  logic                poll_valid,
    input  logic [LVL_W-1:0]    poll_pin,
    output logic [DATA_W-1:0]   rdata,
    output logic                poll_taken,
    output logic                ack_valid,
    output logic [LVL_W-1:0]    ack_lvl
);

    logic [DATA_W-1:0] rd_next;

    // Poll consumption and the acknowledge to the core.
    always_comb begin
        poll_taken = rd_en && poll_pend;
        ack_valid  = poll_taken && poll_valid;
        ack_lvl    = poll_pin;
    end

    // Select the value the current read returns.
    always_comb begin
        rd_next = '0;
        if (poll_pend) begin
            if (poll_valid) rd_next[LVL_W-1:0] = poll_pin;
            else            rd_next[LVL_W-1:0] = '1;
        end else if (addr) begin
            rd_next[NUM_PINS-1:0] = mask;
        end else if (read_isr) begin
            rd_next[NUM_PINS-1:0] = isr_in;
        end else begin
            rd_next[NUM_PINS-1:0] = irr_in;
        end
    end

    // Register the read data on the strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

endmodule

// File: rtl/pic_cmd_regif.sv
// Top of the command register interface for one eight-input controller.
// Decodes bus writes, instantiates the sequencer, decoder and read path,
// and merges their strobes into a single core command channel.
// Assumes wr_en and rd_en are never asserted in the same cycle.
module pic_cmd_regif
    import pic_cmd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_PINS = 8,
    parameter int LVL_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic                addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [NUM_PINS-1:0] irr_in,
    input  logic [NUM_PINS-1:0] isr_in,
    input  logic                poll_valid,
    input  logic [LVL_W-1:0]    poll_pin,
    output logic [NUM_PINS-1:0] mask_o,
    output logic [DATA_W-1:0]   vec_base_o,
    output logic                nested_o,
    output logic                auto_eoi_o,
    output logic                rot_aeoi_o,
    output logic                spec_mask_o,
    output logic                read_isr_o,
    output logic [2:0]          core_cmd_o,
    output logic [LVL_W-1:0]    core_lvl_o
);

    logic             ctl_wr;
    logic             data_wr;
    logic             init_hit;
    logic             poll_pend;
    logic             poll_taken;
    logic             ack_valid;
    logic [LVL_W-1:0] ack_lvl;
    core_cmd_e        op_cmd;
    logic [LVL_W-1:0] op_lvl;
    seq_e             seq_state;

    // Address decode of the write strobe.
    always_comb begin
        ctl_wr   = wr_en && !addr;
        data_wr  = wr_en && addr;
        init_hit = ctl_wr && wdata[B_INIT];
    end

    pic_init_seq #(
        .DATA_W   (DATA_W),
        .NUM_PINS (NUM_PINS),
        .LVL_W    (LVL_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_hit (init_hit),
        .data_wr  (data_wr),
        .wdata    (wdata),
        .mask     (mask_o),
        .vec_base (vec_base_o),
        .nested   (nested_o),
        .aeoi     (auto_eoi_o),
        .state    (seq_state)
    );

    pic_ocw_dec #(
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W)
    ) dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .init_hit   (init_hit),
        .poll_taken (poll_taken),
        .wdata      (wdata),
        .rot_aeoi   (rot_aeoi_o),
        .spec_mask  (spec_mask_o),
        .read_isr   (read_isr_o),
        .poll_pend  (poll_pend),
        .op_cmd     (op_cmd),
        .op_lvl     (op_lvl)
    );

    pic_rd_path #(
        .DATA_W   (DATA_W),
        .NUM_PINS (NUM_PINS),
        .LVL_W    (LVL_W)
    ) rd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .addr       (addr),
        .poll_pend  (poll_pend),
        .read_isr   (read_isr_o),
        .irr_in     (irr_in),
        .isr_in     (isr_in),
        .mask       (mask_o),
        .poll_valid (poll_valid),
        .poll_pin   (poll_pin),
        .rdata      (rdata),
        .poll_taken (poll_taken),
        .ack_valid  (ack_valid),
        .ack_lvl    (ack_lvl)
    );

    // Merge the three strobe sources onto the core command channel.
    always_comb begin
        core_cmd_o = CMD_NONE;
        core_lvl_o = '0;
        if (init_hit) begin
            core_cmd_o = CMD_INIT;
        end else if (op_cmd != CMD_NONE) begin
            core_cmd_o = op_cmd;
            core_lvl_o = op_lvl;
        end else if (ack_valid) begin
            core_cmd_o = CMD_POLL_ACK;
            core_lvl_o = ack_lvl;
        end
    end

endmodule

// File: rtl/pic_cmd_regif_chk.sv
// Property checker for pic_cmd_regif, attached by bind below.
// Observes ports plus the sequencer state and the poll flag.
module pic_cmd_regif_chk
    import pic_cmd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_PINS = 8,
    parameter int LVL_W    = $clog2(NUM_PINS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic                addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rdata,
    input logic                poll_valid,
    input logic [LVL_W-1:0]    poll_pin,
    input logic [NUM_PINS-1:0] mask_o,
    input logic [DATA_W-1:0]   vec_base_o,
    input logic                nested_o,
    input logic                auto_eoi_o,
    input logic [2:0]          core_cmd_o,
    input logic [LVL_W-1:0]    core_lvl_o,
    input logic [1:0]          seq_state,
    input logic                poll_pend
);

    localparam logic [DATA_W-1:0] VEC_KEEP = {{(DATA_W-LVL_W){1'b1}}, {LVL_W{1'b0}}};

    a_r11_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_o == '0 && vec_base_o == '0 && !nested_o &&
                          !auto_eoi_o && rdata == '0 && seq_state == SEQ_IDLE));

    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[B_INIT]) |=> (mask_o == '0 && seq_state == SEQ_BASE));

    a_r4_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && seq_state == SEQ_BASE) |=>
            (vec_base_o == ($past(wdata) & VEC_KEEP)));

    a_r6_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && seq_state == SEQ_MODE) |=>
            (nested_o == $past(wdata[B_NEST]) && auto_eoi_o == $past(wdata[B_AEOI]) &&
             seq_state == SEQ_IDLE));

    a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && seq_state == SEQ_IDLE) |=> (mask_o == $past(wdata[NUM_PINS-1:0])));

    a_r9_cmd_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        (core_cmd_o != CMD_NONE) |-> (wr_en || rd_en));

    a_r12_poll_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_pend && poll_valid) |->
            (core_cmd_o == CMD_POLL_ACK && core_lvl_o == poll_pin));

    a_r12_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !poll_pend);

    a_r13_poll_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_pend && !poll_valid) |=> (rdata == DATA_W'(NUM_PINS - 1)));

endmodule

bind pic_cmd_regif pic_cmd_regif_chk #(
    .DATA_W   (DATA_W),
    .NUM_PINS (NUM_PINS),
    .LVL_W    (LVL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .poll_valid (poll_valid),
    .poll_pin   (poll_pin),
    .mask_o     (mask_o),
    .vec_base_o (vec_base_o),
    .nested_o   (nested_o),
    .auto_eoi_o (auto_eoi_o),
    .core_cmd_o (core_cmd_o),
    .core_lvl_o (core_lvl_o),
    .seq_state  (seq_state),
    .poll_pend  (poll_pend)
);

// File: tb/pic_cmd_regif_tb.sv
// Scoreboard bench: the driver queues expected command strobes and read data,
// and the monitor pops and compares them as each access completes.
module pic_cmd_regif_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] irr_in = '0;
    logic [7:0] isr_in = '0;
    logic       poll_valid = 1'b0;
    logic [2:0] poll_pin = '0;
    logic [7:0] mask_o;
    logic [7:0] vec_base_o;
    logic       nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, read_isr_o;
    logic [2:0] core_cmd_o;
    logic [2:0] core_lvl_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    string      req_q[$];
    bit         kind_q[$];
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    pic_cmd_regif dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
        .poll_valid(poll_valid), .poll_pin(poll_pin), .mask_o(mask_o),
        .vec_base_o(vec_base_o), .nested_o(nested_o), .auto_eoi_o(auto_eoi_o),
        .rot_aeoi_o(rot_aeoi_o), .spec_mask_o(spec_mask_o), .read_isr_o(read_isr_o),
        .core_cmd_o(core_cmd_o), .core_lvl_o(core_lvl_o)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cm(int c, int l);
        return {2'b00, c[2:0], l[2:0]};
    endfunction

    // Driver: queue expectations, then hold the strobe for one cycle.
    task automatic bus_op(bit is_rd, bit a, logic [7:0] d, logic [7:0] exp_cmd,
                          logic [7:0] exp_rd, string req);
        req_q.push_back(req); kind_q.push_back(1'b0); exp_q.push_back(exp_cmd);
        if (is_rd) begin
            req_q.push_back(req); kind_q.push_back(1'b1); exp_q.push_back(exp_rd);
        end
        @(negedge clk);
        addr = a; wdata = d;
        if (is_rd) rd_en = 1'b1; else wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(bit a, logic [7:0] d, logic [7:0] exp_cmd, string req);
        bus_op(1'b0, a, d, exp_cmd, 8'h00, req);
    endtask

    task automatic rd(bit a, logic [7:0] exp_rd, logic [7:0] exp_cmd, string req);
        bus_op(1'b1, a, 8'h00, exp_cmd, exp_rd, req);
    endtask

    // Monitor: compare the strobe mid-cycle, then rdata just after the edge.
    always begin
        @(negedge clk);
        #3;
        if (rst_n && (wr_en || rd_en)) begin
            if (req_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard: access with no expectation");
            end else begin
                check(req_q.pop_front(), {2'b00, core_cmd_o, core_lvl_o}, exp_q.pop_front());
                void'(kind_q.pop_front());
            end
            if (rd_en) begin
                @(posedge clk);
                #1;
                if (req_q.size() != 0) begin
                    check(req_q.pop_front(), rdata, exp_q.pop_front());
                    void'(kind_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mask", mask_o, 8'h00);
        check("R1 vec", vec_base_o, 8'h00);
        check("R1 flags", {3'b0, nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, read_isr_o}, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        check("R1 cmd", {2'b00, core_cmd_o, core_lvl_o}, 8'h00);

        // R7 and R11: normal mask load and readback
        wr(1, 8'hA5, cm(0, 0), "R7 mask write");
        check("R7 mask", mask_o, 8'hA5);
        rd(1, 8'hA5, cm(0, 0), "R11 mask read");

        // R2, R4, R5, R6: full sequence with mode word
        wr(0, 8'h11, cm(1, 0), "R2 init strobe");
        check("R2 mask cleared", mask_o, 8'h00);
        wr(1, 8'h5D, cm(0, 0), "R4 base word");
        check("R4 vec base", vec_base_o, 8'h58);
        check("R7 mask untouched in init", mask_o, 8'h00);
        wr(1, 8'hFF, cm(0, 0), "R5 skipped word");
        check("R5 vec unchanged", vec_base_o, 8'h58);
        check("R5 mask unchanged", mask_o, 8'h00);
        wr(1, 8'h12, cm(0, 0), "R6 mode word");
        check("R6 nested", {7'b0, nested_o}, 8'h01);
        check("R6 aeoi", {7'b0, auto_eoi_o}, 8'h01);
        wr(1, 8'h3C, cm(0, 0), "R6 back to normal");
        check("R6 mask after mode", mask_o, 8'h3C);

        // R8: special mask and read select
        wr(0, 8'h68, cm(0, 0), "R8 smm set");
        check("R8 spec mask", {7'b0, spec_mask_o}, 8'h01);
        wr(0, 8'h0B, cm(0, 0), "R8 sel isr");
        check("R8 read sel", {7'b0, read_isr_o}, 8'h01);
        isr_in = 8'h44; irr_in = 8'h81;
        rd(0, 8'h44, cm(0, 0), "R11 isr read");
        wr(0, 8'h0A, cm(0, 0), "R8 sel irr");
        rd(0, 8'h81, cm(0, 0), "R11 irr read");
        wr(0, 8'h09, cm(0, 0), "R8 sel no enable");
        check("R8 sel held", {7'b0, read_isr_o}, 8'h00);
        wr(0, 8'h0B, cm(0, 0), "R8 sel isr again");

        // R3: init with mode word keeps nested/aeoi, then clear paths
        wr(0, 8'h11, cm(1, 0), "R3 init keep");
        check("R3 nested kept", {7'b0, nested_o}, 8'h01);
        check("R3 aeoi kept", {7'b0, auto_eoi_o}, 8'h01);
        check("R2 smm cleared", {7'b0, spec_mask_o}, 8'h00);
        check("R2 sel cleared", {7'b0, read_isr_o}, 8'h00);
        wr(1, 8'h08, cm(0, 0), "R4 base 2");
        wr(1, 8'h00, cm(0, 0), "R5 skip 2");
        wr(1, 8'h02, cm(0, 0), "R6 mode 2");
        check("R6 nested off", {7'b0, nested_o}, 8'h00);
        check("R6 aeoi on", {7'b0, auto_eoi_o}, 8'h01);
        wr(0, 8'h10, cm(1, 0), "R3 init clear");
        check("R3 aeoi cleared", {7'b0, auto_eoi_o}, 8'h00);
        wr(1, 8'h27, cm(0, 0), "R4 base 3");
        check("R4 vec base 3", vec_base_o, 8'h20);
        wr(1, 8'hEE, cm(0, 0), "R5 skip no mode");
        wr(1, 8'h0F, cm(0, 0), "R5 returns normal");
        check("R5 mask loads", mask_o, 8'h0F);
        check("R5 nested untouched", {7'b0, nested_o}, 8'h00);

        // R9 and R10: operation commands
        wr(0, 8'h80, cm(0, 0), "R10 rot set");
        check("R10 rot on", {7'b0, rot_aeoi_o}, 8'h01);
        wr(0, 8'h40, cm(0, 0), "R10 nop");
        check("R10 rot held", {7'b0, rot_aeoi_o}, 8'h01);
        check("R10 mask held", mask_o, 8'h0F);
        wr(0, 8'h00, cm(0, 0), "R10 rot clr");
        check("R10 rot off", {7'b0, rot_aeoi_o}, 8'h00);
        wr(0, 8'h20, cm(2, 0), "R9 eoi");
        wr(0, 8'hA0, cm(3, 0), "R9 rot eoi");
        wr(0, 8'h65, cm(4, 5), "R9 spec eoi");
        wr(0, 8'hE3, cm(5, 3), "R9 rot spec eoi");
        wr(0, 8'hC6, cm(6, 6), "R9 set prio");

        // R12 and R13: poll reads
        poll_valid = 1'b1; poll_pin = 3'd5;
        wr(0, 8'h0C, cm(0, 0), "R12 arm poll");
        rd(0, 8'h05, cm(7, 5), "R12 poll read");
        rd(0, 8'h81, cm(0, 0), "R12 poll consumed");
        poll_valid = 1'b0;
        wr(0, 8'h0C, cm(0, 0), "R13 arm poll");
        rd(1, 8'h07, cm(0, 0), "R13 empty poll");
        rd(1, 8'h0F, cm(0, 0), "R13 next read normal");
        repeat (3) @(negedge clk);
        check("R11 rdata holds", rdata, 8'h0F);

        if (req_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", req_q.size());
        end
        finish_run();
    end

endmodule